// File: doc/BRIEF.md
# Converter Fault Monitor with Timed Recovery

This block supervises a power converter from its sampled voltages. Each time a fresh input-voltage code arrives, it is tested against an undervoltage/overvoltage window. Each time a fresh output-voltage code arrives, it is compared with the reference code that is live in that cycle, so a reference that is still ramping is tracked rather than a fixed target. An output that strays too far from the reference is only treated as a fault once it has stayed out of band for longer than a set number of millisecond ticks.

Either check latches a fault flag. The flag drives the shutdown request and records which checks tripped. The flag drops by itself only after every check has been quiet for a recovery period, also counted in millisecond ticks. Monitoring never pauses: samples are evaluated whatever the state of the converter's sequencing logic, which sits outside this block.

Top module: `conv_fault_monitor`

## Requirements
- R1: After reset, `fault`, `cause` and `shutdown_req` are all zero.
- R2: An input sample strobed with `vin_code < UV_TRIP` or `vin_code > OV_TRIP` makes `fault` high with `cause[0]` set, visible after the second rising edge counting the edge that captures the strobe. Codes presented without `vin_vld` have no effect.
- R3: While the input check is not active, codes within [UV_TRIP, OV_TRIP] do not activate it. Once active, it stays active until a strobed code within [UV_CLEAR, OV_CLEAR] arrives.
- R4: An output sample is out of band when |`vout_code` − `ref_code`| > REG_TRIP, using the reference present in the strobe cycle. Once out of band, only a sample with a difference ≤ REG_CLEAR brings it back in band.
- R5: A regulation fault (`cause[1]`) trips only after PERSIST_MS+1 millisecond ticks have been counted while out of band. `fault` is visible one edge after the edge that captures the tripping tick.
- R6: An output sample that falls back in band resets the persistence count to zero.
- R7: `cause` bit 0 (input window) and bit 1 (regulation) accumulate while `fault` is held. Both bits are zero whenever `fault` is low.
- R8: With no check active, `fault` clears on the edge that captures the RECOVER_MS-th millisecond tick. A check becoming active again restarts this count from zero.
- R9: `shutdown_req` equals `fault` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vin_vld | input | 1 | Input-voltage sample strobe |
| vin_code | input | W | Input-voltage code |
| vout_vld | input | 1 | Output-voltage sample strobe |
| vout_code | input | W | Output-voltage code |
| ref_code | input | W | Live regulation reference code |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| fault | output | 1 | Latched fault flag |
| cause | output | 2 | Tripped checks: bit 0 input window, bit 1 regulation |
| shutdown_req | output | 1 | Shutdown request to the power stage |

## Verification
An input strobe captured on one edge shows up on `fault` after the next edge. The bench therefore checks that `fault` is still low at the falling edge right after capture, and that it is high one cycle later. The tick that completes persistence behaves the same way, so the bench samples both at the falling edge before the flag moves and at the one after. Recovery acts on the capturing edge itself, so the flag is checked as still set after RECOVER_MS−1 ticks and clear at the falling edge right after the last tick. The input code range and a span of output-minus-reference differences are swept, each from reset, against thresholds evaluated arithmetically in the bench.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
    localparam int CAUSE_W   = 2;
    localparam int CAUSE_VIN = 0;
    localparam int CAUSE_REG = 1;
endpackage

// File: rtl/fmon_window.sv
module fmon_window #(
    parameter int          W        = 12,
    parameter int unsigned UV_TRIP  = 1000,
    parameter int unsigned UV_CLEAR = 1100,
    parameter int unsigned OV_TRIP  = 3000,
    parameter int unsigned OV_CLEAR = 2900
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_code,
    output logic         bad
);
    localparam logic [W-1:0] UV_T = W'(UV_TRIP);
    localparam logic [W-1:0] UV_C = W'(UV_CLEAR);
    localparam logic [W-1:0] OV_T = W'(OV_TRIP);
    localparam logic [W-1:0] OV_C = W'(OV_CLEAR);

    typedef struct packed {
        logic bad;
    } win_s;

    win_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (smp_vld) begin
            if (!s_q.bad) begin
                s_d.bad = (smp_code < UV_T) || (smp_code > OV_T);
            end else if ((smp_code >= UV_C) && (smp_code <= OV_C)) begin
                s_d.bad = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bad = s_q.bad;
endmodule

// File: rtl/fmon_regcheck.sv
module fmon_regcheck #(
    parameter int          W          = 12,
    parameter int unsigned REG_TRIP   = 100,
    parameter int unsigned REG_CLEAR  = 80,
    parameter int unsigned PERSIST_MS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_code,
    input  logic [W-1:0] ref_code,
    input  logic         ms_tick,
    output logic         reg_err
);
    localparam int           CW    = $clog2(PERSIST_MS + 2);
    localparam logic [CW-1:0] LIMIT = CW'(PERSIST_MS + 1);
    localparam logic [W-1:0]  BAND_T = W'(REG_TRIP);
    localparam logic [W-1:0]  BAND_C = W'(REG_CLEAR);

    typedef struct packed {
        logic          oob;
        logic [CW-1:0] cnt;
    } reg_s;

    reg_s         s_d, s_q;
    logic [W-1:0] diff;

    always_comb begin
        diff = (smp_code >= ref_code) ? (smp_code - ref_code) : (ref_code - smp_code);
    end

    always_comb begin
        s_d = s_q;
        if (smp_vld) begin
            if (!s_q.oob)              s_d.oob = (diff > BAND_T);
            else if (diff <= BAND_C)   s_d.oob = 1'b0;
        end
        if (smp_vld && !s_d.oob) begin
            s_d.cnt = '0;
        end else if (s_q.oob && ms_tick && (s_q.cnt != LIMIT)) begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_err = (s_q.cnt == LIMIT);
endmodule

// File: rtl/fmon_latch.sv
module fmon_latch
    import fmon_pkg::*;
#(
    parameter int unsigned RECOVER_MS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cond,
    input  logic               ms_tick,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);
    localparam int            RW   = $clog2(RECOVER_MS + 1);
    localparam logic [RW-1:0] LAST = RW'(RECOVER_MS - 1);

    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [RW-1:0]      rec;
    } lat_s;

    lat_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cond != '0) begin
            s_d.fault = 1'b1;
            s_d.cause = s_q.cause | cond;
            s_d.rec   = '0;
        end else if (s_q.fault && ms_tick) begin
            if (s_q.rec == LAST) begin
                s_d = '0;
            end else begin
                s_d.rec = s_q.rec + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fault = s_q.fault;
    assign cause = s_q.cause;
endmodule

// File: rtl/conv_fault_monitor.sv
module conv_fault_monitor
    import fmon_pkg::*;
#(
    parameter int          W          = 12,
    parameter int unsigned UV_TRIP    = 1000,
    parameter int unsigned UV_CLEAR   = 1100,
    parameter int unsigned OV_TRIP    = 3000,
    parameter int unsigned OV_CLEAR   = 2900,
    parameter int unsigned REG_TRIP   = 100,
    parameter int unsigned REG_CLEAR  = 80,
    parameter int unsigned PERSIST_MS = 10,
    parameter int unsigned RECOVER_MS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vin_vld,
    input  logic [W-1:0]       vin_code,
    input  logic               vout_vld,
    input  logic [W-1:0]       vout_code,
    input  logic [W-1:0]       ref_code,
    input  logic               ms_tick,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause,
    output logic               shutdown_req
);
    logic               vin_bad;
    logic               reg_err;
    logic [CAUSE_W-1:0] cond;

    fmon_window #(
        .W(W), .UV_TRIP(UV_TRIP), .UV_CLEAR(UV_CLEAR),
        .OV_TRIP(OV_TRIP), .OV_CLEAR(OV_CLEAR)
    ) i_window (
        .clk(clk), .rst_n(rst_n), .smp_vld(vin_vld), .smp_code(vin_code), .bad(vin_bad)
    );

    fmon_regcheck #(
        .W(W), .REG_TRIP(REG_TRIP), .REG_CLEAR(REG_CLEAR), .PERSIST_MS(PERSIST_MS)
    ) i_regcheck (
        .clk(clk), .rst_n(rst_n), .smp_vld(vout_vld), .smp_code(vout_code),
        .ref_code(ref_code), .ms_tick(ms_tick), .reg_err(reg_err)
    );

    always_comb begin
        cond            = '0;
        cond[CAUSE_VIN] = vin_bad;
        cond[CAUSE_REG] = reg_err;
    end

    fmon_latch #(
        .RECOVER_MS(RECOVER_MS)
    ) i_latch (
        .clk(clk), .rst_n(rst_n), .cond(cond), .ms_tick(ms_tick),
        .fault(fault), .cause(cause)
    );

    assign shutdown_req = fault;
endmodule

// File: rtl/fmon_chk.sv
module fmon_chk #(
    parameter int          W       = 12,
    parameter int unsigned UV_TRIP = 1000,
    parameter int unsigned OV_TRIP = 3000
) (
    input logic         clk,
    input logic         rst_n,
    input logic         vin_vld,
    input logic [W-1:0] vin_code,
    input logic         ms_tick,
    input logic         fault,
    input logic [1:0]   cause
);
    localparam logic [W-1:0] UV_T = W'(UV_TRIP);
    localparam logic [W-1:0] OV_T = W'(OV_TRIP);

    // R2
    vin_low_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vin_vld && (vin_code < UV_T)) |=> ##1 (fault && cause[0]));

    // R2
    vin_high_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vin_vld && (vin_code > OV_T)) |=> ##1 (fault && cause[0]));

    // R7
    cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (cause == 2'b00));

    // R7
    cause_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> (cause != 2'b00));

    // R7
    cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault)) |-> ((cause & $past(cause)) == $past(cause)));

    // R8
    clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(ms_tick));
endmodule

bind conv_fault_monitor fmon_chk #(
    .W(W), .UV_TRIP(UV_TRIP), .OV_TRIP(OV_TRIP)
) i_fmon_chk (
    .clk(clk), .rst_n(rst_n), .vin_vld(vin_vld), .vin_code(vin_code),
    .ms_tick(ms_tick), .fault(fault), .cause(cause)
);

// File: tb/test_conv_fault_monitor.sv
`timescale 1ns/1ps
module test_conv_fault_monitor;
    localparam int W  = 12;
    localparam int UT = 1000, UC = 1100, OT = 3000, OC = 2900;
    localparam int RT = 100,  RC = 80,   PM = 10,   RM = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vin_vld = 1'b0, vout_vld = 1'b0, ms_tick = 1'b0;
    logic [W-1:0] vin_code = 12'd2000, vout_code = 12'd2000, ref_code = 12'd2000;
    logic         fault, shutdown_req;
    logic [1:0]   cause;

    int nvec = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    conv_fault_monitor #(
        .W(W), .UV_TRIP(UT), .UV_CLEAR(UC), .OV_TRIP(OT), .OV_CLEAR(OC),
        .REG_TRIP(RT), .REG_CLEAR(RC), .PERSIST_MS(PM), .RECOVER_MS(RM)
    ) i_conv_fault_monitor (
        .clk(clk), .rst_n(rst_n), .vin_vld(vin_vld), .vin_code(vin_code),
        .vout_vld(vout_vld), .vout_code(vout_code), .ref_code(ref_code),
        .ms_tick(ms_tick), .fault(fault), .cause(cause), .shutdown_req(shutdown_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // fault, cause and the R9 relation in one go
    task automatic chk_state(input string req, input int f, input int c);
        chk(req, fault, f);
        chk(req, cause, c);
        chk("R9", shutdown_req, f);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vin_vld = 0; vout_vld = 0; ms_tick = 0;
        vin_code = 12'd2000; vout_code = 12'd2000; ref_code = 12'd2000;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic vin_smp(input int v);
        @(negedge clk); vin_code = v[W-1:0]; vin_vld = 1'b1;
        @(negedge clk); vin_vld = 1'b0;
    endtask

    task automatic vout_smp(input int vo, input int rf);
        @(negedge clk); vout_code = vo[W-1:0]; ref_code = rf[W-1:0]; vout_vld = 1'b1;
        @(negedge clk); vout_vld = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vin_point(input int v);
        bit exp;
        exp = (v < UT) || (v > OT);
        do_reset();
        vin_smp(v);
        chk_state("R2", 0, 0);
        idle(1);
        chk_state("R2", exp, exp ? 1 : 0);
    endtask

    task automatic reg_point(input int d);
        bit exp;
        exp = ((d < 0) ? -d : d) > RT;
        do_reset();
        vout_smp(2000 + d, 2000);
        ticks(PM);
        idle(2);
        chk_state("R5", 0, 0);
        tick();
        chk_state("R5", 0, 0);
        idle(1);
        chk_state("R4", exp, exp ? 2 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nvec++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        // R1
        idle(2);
        chk_state("R1", 0, 0);
        rst_n = 1'b1;
        idle(2);
        chk_state("R1", 0, 0);

        // R2 sweep of input codes plus window edges
        for (int v = 0; v < 4096; v += 15) vin_point(v);
        vin_point(999);  vin_point(1000); vin_point(3000); vin_point(3001); vin_point(4095);

        // R2: code without strobe is ignored
        do_reset();
        @(negedge clk); vin_code = 12'd0;
        idle(3);
        chk_state("R2", 0, 0);

        // R3 undervoltage hysteresis
        do_reset();
        vin_smp(1050); idle(1); chk_state("R3", 0, 0);
        vin_smp(900);  idle(1); chk_state("R3", 1, 1);
        vin_smp(1099); ticks(RM + 2); chk_state("R3", 1, 1);
        vin_smp(1100); ticks(RM - 1); chk_state("R8", 1, 1);
        tick(); chk_state("R8", 0, 0);

        // R3 overvoltage hysteresis
        do_reset();
        vin_smp(2950); idle(1); chk_state("R3", 0, 0);
        vin_smp(3001); idle(1); chk_state("R3", 1, 1);
        vin_smp(2901); ticks(RM + 2); chk_state("R3", 1, 1);
        vin_smp(2900); ticks(RM); chk_state("R3", 0, 0);

        // R4 / R5 sweep of output-minus-reference
        for (int d = -220; d <= 220; d += 4) reg_point(d);
        reg_point(100); reg_point(101); reg_point(-100); reg_point(-101);

        // R4 band hysteresis: 90 keeps it out of band
        do_reset();
        vout_smp(2150, 2000); ticks(5);
        vout_smp(2090, 2000); ticks(PM + 1 - 5);
        idle(1); chk_state("R4", 1, 2);
        // R4: 80 brings it back, then 90 does not re-trip
        do_reset();
        vout_smp(2150, 2000); ticks(5);
        vout_smp(2080, 2000);
        vout_smp(2090, 2000); ticks(PM + 1);
        idle(2); chk_state("R4", 0, 0);

        // R6 persistence count restarts on an in-band sample
        do_reset();
        vout_smp(2200, 2000); ticks(PM);
        vout_smp(2000, 2000); ticks(PM);
        vout_smp(2200, 2000); ticks(PM);
        idle(2); chk_state("R6", 0, 0);
        tick(); idle(1); chk_state("R6", 1, 2);

        // R4 live ramping reference: tracking output stays healthy
        do_reset();
        for (int i = 0; i < 50; i++) begin
            vout_smp(1000 + 20 * i - 30, 1000 + 20 * i);
            tick();
        end
        idle(2); chk_state("R4", 0, 0);
        vout_smp(2000, 2150); ticks(PM + 1);
        idle(1); chk_state("R4", 1, 2);

        // R8 recovery restarts when a check re-activates
        do_reset();
        vin_smp(900); idle(1); chk_state("R8", 1, 1);
        vin_smp(2000); ticks(RM - 1); chk_state("R8", 1, 1);
        vin_smp(500);
        vin_smp(2000); ticks(RM - 1); chk_state("R8", 1, 1);
        tick(); chk_state("R8", 0, 0);

        // R7 cause bits accumulate over one fault episode
        do_reset();
        vin_smp(3100); idle(1); chk_state("R7", 1, 1);
        vout_smp(2300, 2000); ticks(PM + 1);
        idle(1); chk_state("R7", 1, 3);
        vin_smp(2000); ticks(RM + 1); chk_state("R7", 1, 3);
        vout_smp(2000, 2000); ticks(RM - 1); chk_state("R7", 1, 3);
        tick(); chk_state("R7", 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule